// File: doc/BRIEF.md
# Big-Endian Sub-Word Store Unit

This block is the store stage that sits between a processor core and a memory organised as 32-bit words. Each cycle it can take one store request. A request carries a size code (byte, halfword or word), a byte address and the register value to be stored. One cycle later the block presents a word address, one write enable for each byte lane, and the write data. The low-order part of the register has been moved into the lanes that the address selects.

Lanes are numbered in big-endian order. Lane 0 is the byte at the lowest address of the word, and it is carried on the most significant data bits. A sub-word store writes only its own lanes, so the memory keeps the other bytes of the word as they were. A request whose address does not suit its size writes nothing. Instead it raises a misalignment flag for one cycle. The core's trap logic consumes that flag.

Top module: `be_store_unit`

## Requirements
- R1: While rst_n is low and after its release with no request, mem_we, mem_be, mem_wdata, mem_waddr and misalign are all zero.
- R2: A word store (size code 2'b10) at address offset 0 sets mem_be to 4'b1111 and drives mem_wdata equal to the register value. The most significant register byte therefore lands at the lowest byte address.
- R3: A halfword store (size code 2'b01) at offset 0 sets mem_be to 4'b0011 and drives the register's bits [15:0] on mem_wdata[31:16].
- R4: A halfword store at offset 2 sets mem_be to 4'b1100 and drives the register's bits [15:0] on mem_wdata[15:0].
- R5: A byte store (size code 2'b00) at offset k (0 to 3) sets only mem_be bit k and drives the register's bits [7:0] on mem_wdata[31-8k -: 8].
- R6: Every data lane whose mem_be bit is low carries zero on mem_wdata.
- R7: A halfword store with address bit 0 set, or a word store with address bits [1:0] nonzero, raises misalign for one cycle with mem_we low and mem_be zero.
- R8: Results are registered. A request presented at a rising edge appears on the outputs after that edge for exactly one cycle. A cycle without a request gives mem_we and misalign low.
- R9: For every accepted request, whether aligned or not, mem_waddr equals address bits [31:2].
- R10: Size code 2'b11 is handled exactly as a word store.
- R11: Sub-word stores leave the other bytes of the addressed memory word unchanged, and misaligned requests change no memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A store request is present this cycle |
| req_size | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| req_addr | input | 32 | Byte address of the store |
| req_data | input | 32 | Register value to store |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables, bit k = lane k = data bits [31-8k -: 8] |
| mem_wdata | output | 32 | Lane-steered write data |
| misalign | output | 1 | The request did not suit its size; nothing was written |

## Verification
Every result, whether strobe, enables, data, word address or misalignment flag, is due in the cycle after the edge that captured its request. The driver applies one request (or an idle slot) per cycle on the falling edge and queues the result it expects. The monitor takes one entry from the queue a short delay after each rising edge, so each comparison falls exactly one register stage after its stimulus, idle cycles included. Memory contents come from a byte-enabled model that the strobe updates, and they are compared once the queue has drained.

// File: rtl/be_store_pkg.sv
package be_store_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } store_size_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/sw_size_decode.sv
module sw_size_decode #(
    parameter int unsigned OFF_W = 2
) (
    input  logic [1:0]       size_code,
    input  logic [OFF_W-1:0] offset,
    output logic [OFF_W-1:0] low_mask,
    output logic             aligned
);
    localparam int unsigned SH_W = (OFF_W + 1 > 1) ? $clog2(OFF_W + 1) : 1;

    logic [SH_W-1:0] shamt;
    logic [OFF_W:0]  span;

    always_comb begin
        if (size_code[1]) begin
            shamt = SH_W'(OFF_W);
        end else if (size_code[0]) begin
            shamt = SH_W'(1);
        end else begin
            shamt = '0;
        end
        span     = (OFF_W + 1)'(1) << shamt;
        low_mask = OFF_W'(span - (OFF_W + 1)'(1));
        aligned  = (offset & low_mask) == '0;
    end
endmodule

// File: rtl/sw_lane_enable.sv
module sw_lane_enable #(
    parameter int unsigned LANES = 4,
    parameter int unsigned OFF_W = 2
) (
    input  logic             active,
    input  logic [OFF_W-1:0] offset,
    input  logic [OFF_W-1:0] low_mask,
    output logic [LANES-1:0] lane_en
);
    logic [OFF_W-1:0] base;

    assign base = offset & ~low_mask;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFF_W-1:0] lane_id;
        assign lane_id    = OFF_W'(k);
        assign lane_en[k] = active && ((lane_id & ~low_mask) == base);
    end
endmodule

// File: rtl/sw_data_steer.sv
module sw_data_steer #(
    parameter int unsigned LANES = 4,
    parameter int unsigned OFF_W = 2
) (
    input  logic [LANES*8-1:0] reg_value,
    input  logic [OFF_W-1:0]   offset,
    input  logic [OFF_W-1:0]   low_mask,
    input  logic [LANES-1:0]   lane_en,
    output logic [LANES*8-1:0] lane_data
);
    import be_store_pkg::BYTE_W;

    localparam int unsigned DATA_W = LANES * BYTE_W;

    logic [OFF_W-1:0] base;

    assign base = offset & ~low_mask;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFF_W-1:0]  src_idx;
        logic [BYTE_W-1:0] picked;
        always_comb begin
            src_idx = base + low_mask - OFF_W'(k);
            picked  = reg_value[int'(src_idx)*BYTE_W +: BYTE_W];
        end
        assign lane_data[DATA_W-1-k*BYTE_W -: BYTE_W] = lane_en[k] ? picked : '0;
    end
endmodule

// File: rtl/be_store_unit.sv
module be_store_unit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      req_valid,
    input  logic [1:0]                                req_size,
    input  logic [ADDR_W-1:0]                         req_addr,
    input  logic [DATA_W-1:0]                         req_data,
    output logic                                      mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]        mem_waddr,
    output logic [DATA_W/8-1:0]                       mem_be,
    output logic [DATA_W-1:0]                         mem_wdata,
    output logic                                      misalign
);
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned OFF_W   = $clog2(LANES);
    localparam int unsigned WADDR_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic               we;
        logic [WADDR_W-1:0] waddr;
        logic [LANES-1:0]   be;
        logic [DATA_W-1:0]  wdata;
        logic               misalign;
    } out_state_t;

    out_state_t state_d, state_q;

    logic [OFF_W-1:0]  offset;
    logic [OFF_W-1:0]  low_mask;
    logic              aligned;
    logic              write_ok;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] lane_data;

    assign offset   = req_addr[OFF_W-1:0];
    assign write_ok = req_valid && aligned;

    sw_size_decode #(.OFF_W(OFF_W)) u_size (
        .size_code (req_size),
        .offset    (offset),
        .low_mask  (low_mask),
        .aligned   (aligned)
    );

    sw_lane_enable #(.LANES(LANES), .OFF_W(OFF_W)) u_lanes (
        .active    (write_ok),
        .offset    (offset),
        .low_mask  (low_mask),
        .lane_en   (lane_en)
    );

    sw_data_steer #(.LANES(LANES), .OFF_W(OFF_W)) u_steer (
        .reg_value (req_data),
        .offset    (offset),
        .low_mask  (low_mask),
        .lane_en   (lane_en),
        .lane_data (lane_data)
    );

    always_comb begin
        state_d = '0;
        if (req_valid) begin
            state_d.waddr = req_addr[ADDR_W-1:OFF_W];
            if (aligned) begin
                state_d.we    = 1'b1;
                state_d.be    = lane_en;
                state_d.wdata = lane_data;
            end else begin
                state_d.misalign = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_we    = state_q.we;
    assign mem_waddr = state_q.waddr;
    assign mem_be    = state_q.be;
    assign mem_wdata = state_q.wdata;
    assign misalign  = state_q.misalign;
endmodule

// File: rtl/be_store_checker.sv
module be_store_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   req_valid,
    input logic [1:0]                             req_size,
    input logic [ADDR_W-1:0]                      req_addr,
    input logic [DATA_W-1:0]                      req_data,
    input logic                                   mem_we,
    input logic [ADDR_W-$clog2(DATA_W/8)-1:0]     mem_waddr,
    input logic [DATA_W/8-1:0]                    mem_be,
    input logic [DATA_W-1:0]                      mem_wdata,
    input logic                                   misalign
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    assert_strobe_has_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != '0));

    assert_no_lanes_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_be == '0));

    assert_idle_gives_nothing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!mem_we && !misalign));

    assert_misalign_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_we && mem_be == '0));

    assert_word_offset_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_size[1] && req_addr[OFF_W-1:0] != '0) |-> misalign);

    assert_half_odd_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_size == 2'b01 && req_addr[0]) |-> misalign);

    assert_word_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_size[1] && req_addr[OFF_W-1:0] == '0)
        |-> (mem_be == '1 && mem_wdata == $past(req_data)));

    assert_byte_single_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_size == 2'b00) |-> ($countones(mem_be) == 1));

    assert_waddr_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> (mem_waddr == $past(req_addr[ADDR_W-1:OFF_W])));

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        assert_quiet_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !mem_be[k] |-> (mem_wdata[DATA_W-1-8*k -: 8] == 8'h00));
    end
endmodule

bind be_store_unit be_store_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .misalign  (misalign)
);

// File: tb/be_store_unit_tb.sv
`timescale 1ns/1ps
module be_store_unit_tb;

    typedef struct {
        logic        we;
        logic [29:0] waddr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        mis;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        mem_we;
    logic [29:0] mem_waddr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        misalign;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    item_t exp_q[$];
    logic [31:0] mem [64];

    always #5 clk = ~clk;

    be_store_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .misalign  (misalign)
    );

    // byte-enabled memory model, filled with spaces during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'h20202020;
        end else if (mem_we) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_waddr[5:0]][31-8*k -: 8] <= mem_wdata[31-8*k -: 8];
        end
    end

    function automatic item_t predict(logic v, logic [1:0] sz, logic [31:0] a,
                                      logic [31:0] d, string tag);
        item_t it;
        it.we = 1'b0; it.waddr = '0; it.be = '0; it.wdata = '0; it.mis = 1'b0;
        it.tag = tag;
        if (v) begin
            it.waddr = a[31:2];
            if (sz == 2'b00) begin
                it.be = 4'b0001 << a[1:0];
                case (a[1:0])
                    2'd0: it.wdata = {d[7:0], 24'h0};
                    2'd1: it.wdata = {8'h0, d[7:0], 16'h0};
                    2'd2: it.wdata = {16'h0, d[7:0], 8'h0};
                    default: it.wdata = {24'h0, d[7:0]};
                endcase
            end else if (sz == 2'b01) begin
                if (a[0]) it.mis = 1'b1;
                else if (!a[1]) begin it.be = 4'b0011; it.wdata = {d[15:0], 16'h0}; end
                else begin it.be = 4'b1100; it.wdata = {16'h0, d[15:0]}; end
            end else begin
                if (a[1:0] != 2'b00) it.mis = 1'b1;
                else begin it.be = 4'b1111; it.wdata = d; end
            end
            it.we = (it.be != 4'b0000);
        end
        return it;
    endfunction

    task automatic store(input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] d, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_addr = a; req_data = d;
        exp_q.push_back(predict(1'b1, sz, a, d, tag));
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0; req_size = 2'b00; req_addr = '0; req_data = '0;
        exp_q.push_back(predict(1'b0, 2'b00, '0, '0, tag));
    endtask

    task automatic check_word(input int idx, input logic [31:0] expv, input string tag);
        n_checks++;
        if (mem[idx] !== expv) begin
            n_fails++;
            $display("FAIL %s: mem word %0d got %h expected %h", tag, idx, mem[idx], expv);
        end
    endtask

    // monitor: one expected item per cycle, compared one register stage later
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (mem_we !== e.we || mem_waddr !== e.waddr || mem_be !== e.be ||
                    mem_wdata !== e.wdata || misalign !== e.mis) begin
                    n_fails++;
                    $display("FAIL %s: got we=%b waddr=%h be=%b data=%h mis=%b expected we=%b waddr=%h be=%b data=%h mis=%b",
                             e.tag, mem_we, mem_waddr, mem_be, mem_wdata, misalign,
                             e.we, e.waddr, e.be, e.wdata, e.mis);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are zero while reset is held
        n_checks++;
        if (mem_we !== 1'b0 || mem_be !== 4'h0 || mem_wdata !== 32'h0 ||
            mem_waddr !== 30'h0 || misalign !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: got we=%b be=%b data=%h waddr=%h mis=%b expected all zero",
                     mem_we, mem_be, mem_wdata, mem_waddr, misalign);
        end
        rst_n = 1'b1;
        idle("R1_after_release");
        idle("R8_idle");

        // worked sequence: word, two halfwords, four bytes
        store(2'b10, 32'd72, 32'h12345678, "R2_word");
        store(2'b01, 32'd76, 32'h12345678, "R3_half_off0");
        store(2'b01, 32'd82, 32'h12345678, "R4_half_off2");
        store(2'b00, 32'd84, 32'h12345678, "R5_byte_off0");
        store(2'b00, 32'd89, 32'h12345678, "R5_byte_off1");
        idle("R8_gap");
        store(2'b00, 32'd94, 32'h12345678, "R5_byte_off2");
        store(2'b00, 32'd99, 32'h12345678, "R5_byte_off3");

        // misaligned requests: R7 and R9
        store(2'b01, 32'd77, 32'hCAFEF00D, "R7_half_odd");
        store(2'b10, 32'd74, 32'hDEADBEEF, "R7_word_off2");
        store(2'b10, 32'd73, 32'hDEADBEEF, "R7_word_off1");
        store(2'b01, 32'd79, 32'hDEADBEEF, "R7_half_off3");

        // R10: reserved size code behaves as word
        store(2'b11, 32'd100, 32'hA1B2C3D4, "R10_wide_code");
        store(2'b11, 32'd102, 32'hA1B2C3D4, "R10_wide_misaligned");

        // back-to-back bytes building one word: R6 and R11
        store(2'b00, 32'd104, 32'hFFFFFF11, "R6_byte0");
        store(2'b00, 32'd105, 32'hFFFFFF22, "R6_byte1");
        store(2'b00, 32'd106, 32'hFFFFFF33, "R6_byte2");
        store(2'b00, 32'd107, 32'hFFFFFF44, "R6_byte3");
        store(2'b01, 32'd108, 32'hFFFFBEEF, "R6_half_upper_bits");
        store(2'b10, 32'd252, 32'h0BADC0DE, "R9_top_word");
        idle("R8_tail");
        idle("R8_tail2");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);

        // R11: memory image after sub-word stores
        check_word(18, 32'h12345678, "R2_mem_word72");
        check_word(19, 32'h56782020, "R11_mem_word76");
        check_word(20, 32'h20205678, "R11_mem_word80");
        check_word(21, 32'h78202020, "R11_mem_word84");
        check_word(22, 32'h20782020, "R11_mem_word88");
        check_word(23, 32'h20207820, "R11_mem_word92");
        check_word(24, 32'h20202078, "R11_mem_word96");
        check_word(25, 32'hA1B2C3D4, "R10_mem_word100");
        check_word(26, 32'h11223344, "R11_mem_word104");
        check_word(27, 32'hBEEF2020, "R11_mem_word108");
        check_word(63, 32'h0BADC0DE, "R9_mem_word252");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule